// File: doc/BRIEF.md
# Dithered Ring Period Sequencer

This block is a synthesizable model of the fine-adjust stage of a variable-length ring oscillator. Each system clock tick stands for one stage delay. An 8-bit stage word sets the length. Its upper three bits choose a nominal ring length of `17 + 2*coarse` stages. Its lower five bits are a fraction `N`. For every output cycle the block runs either the nominal length or a length two stages longer. Across each 32-cycle frame exactly `N` cycles are long, so the average period takes a non-integer number of stages.

A 5-bit phase accumulator adds `N` once per output cycle. A cycle is long when that addition carries out. This spreads the long cycles as evenly as the frame allows. The stage word is sampled only on the first tick of each output cycle, so a period is never cut short.

A two-state machine shapes the output clock. `PH_HIGH` holds the clock high from tick zero. It moves to `PH_LOW` on the tick numbered one less than half the length, rounded down. `PH_LOW` holds the clock low and returns to `PH_HIGH` on the final tick of the period, when the tick counter wraps to zero. Reset enters `PH_HIGH` at tick zero. The length of the cycle in progress and its long flag are brought out so the behaviour can be checked.

Top module: `ring_dither_seq`

## Requirements
- R1: With stage_word[7:5] = c and stage_word[4:0] = 0, every output cycle lasts 17 + 2c ticks, and long_cycle stays low.
- R2: A long cycle lasts two ticks more than the nominal length, and long_cycle is high for its whole duration.
- R3: With a constant fraction N = stage_word[4:0], exactly N of the first 32 output cycles after reset are long.
- R4: Counting output cycles from k = 1 after reset, cycle k is long exactly when floor(k*N/32) is greater than floor((k-1)*N/32).
- R5: ring_clk is high for the first floor(L/2) ticks of a cycle of length L and low for the remaining ticks.
- R6: A change to stage_word in the middle of a cycle does not alter that cycle's length or stage_count. It applies from the next cycle.
- R7: While reset is held, the block sits at tick zero with ring_clk high and cycle_start high. Reset also clears the phase accumulator, so the cycles after reset follow the R4 sequence again from k = 1.
- R8: stage_count equals the length in ticks of the cycle in progress and is constant for the whole cycle.
- R9: cycle_start is high only on the first tick of each output cycle, and ring_clk rises only on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick is one stage delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_word | input | 8 | Coarse length in bits [7:5], dither fraction in bits [4:0] |
| ring_clk | output | 1 | Generated ring clock |
| cycle_start | output | 1 | High on the first tick of each output cycle |
| long_cycle | output | 1 | High during a cycle that uses the longer length |
| stage_count | output | 6 | Length in ticks of the cycle in progress |

## Verification
The bench builds the block with its default parameters: three coarse bits, five fraction bits, a base of 17 stages and a step of 2. With these values a full 32-cycle frame and the longest 33-tick period fit in a short run. The bench therefore checks the long-cycle count over complete frames and the exact placement of long cycles for fractions 1, 5, 16 and 31. It also covers the extreme coarse settings, a stage word change in mid-period, and a reset in mid-period that must restart the dither sequence.

// File: rtl/ring_dither_pkg.sv
package ring_dither_pkg;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } ring_phase_e;

endpackage

// File: rtl/ring_dither_acc.sv
module ring_dither_acc #(
    parameter int FINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [FINE_W-1:0] fine,
    output logic              carry
);
    logic [FINE_W-1:0] phase_q;
    logic [FINE_W:0]   sum;

    always_comb begin
        sum   = {1'b0, phase_q} + {1'b0, fine};
        carry = sum[FINE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= sum[FINE_W-1:0];
        end
    end
endmodule

// File: rtl/ring_dither_len.sv
module ring_dither_len #(
    parameter int COARSE_W    = 3,
    parameter int BASE_STAGES = 17,
    parameter int STAGE_STEP  = 2,
    parameter int LEN_W       = 6
) (
    input  logic [COARSE_W-1:0] coarse,
    input  logic                lengthen,
    output logic [LEN_W-1:0]    len
);
    localparam logic [LEN_W-1:0] BASE_L = LEN_W'(BASE_STAGES);
    localparam logic [LEN_W-1:0] STEP_L = LEN_W'(STAGE_STEP);

    logic [LEN_W-1:0] coarse_ext;

    always_comb begin
        coarse_ext = LEN_W'(coarse);
        len        = BASE_L + STEP_L * coarse_ext;
        if (lengthen) begin
            len = len + STEP_L;
        end
    end
endmodule

// File: rtl/ring_dither_fsm.sv
module ring_dither_fsm
    import ring_dither_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cur_len,
    output logic             at_start,
    output logic             ring_clk
);
    ring_phase_e      state_q, state_d;
    logic [LEN_W-1:0] tick_q, tick_d;
    logic [LEN_W-1:0] half_len;
    logic             last_tick;

    always_comb begin
        half_len  = cur_len >> 1;
        last_tick = (tick_q == cur_len - LEN_W'(1));
        tick_d    = last_tick ? '0 : tick_q + LEN_W'(1);
        state_d   = state_q;
        unique case (state_q)
            PH_HIGH: if (tick_q == half_len - LEN_W'(1)) state_d = PH_LOW;
            PH_LOW:  if (last_tick)                      state_d = PH_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_HIGH;
            tick_q  <= '0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
        end
    end

    always_comb begin
        at_start = (tick_q == '0);
        ring_clk = (state_q == PH_HIGH);
    end
endmodule

// File: rtl/ring_dither_seq.sv
module ring_dither_seq #(
    parameter int COARSE_W    = 3,
    parameter int FINE_W      = 5,
    parameter int BASE_STAGES = 17,
    parameter int STAGE_STEP  = 2,
    localparam int WORD_W     = COARSE_W + FINE_W,
    localparam int MAX_LEN    = BASE_STAGES + STAGE_STEP * (2**COARSE_W - 1) + STAGE_STEP,
    localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] stage_word,
    output logic              ring_clk,
    output logic              cycle_start,
    output logic              long_cycle,
    output logic [LEN_W-1:0]  stage_count
);
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
    logic                carry;
    logic [LEN_W-1:0]    next_len;
    logic [LEN_W-1:0]    len_q;
    logic                long_q;
    logic                at_start;

    assign coarse = stage_word[WORD_W-1:FINE_W];
    assign fine   = stage_word[FINE_W-1:0];

    ring_dither_acc #(.FINE_W(FINE_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (at_start),
        .fine    (fine),
        .carry   (carry)
    );

    ring_dither_len #(
        .COARSE_W    (COARSE_W),
        .BASE_STAGES (BASE_STAGES),
        .STAGE_STEP  (STAGE_STEP),
        .LEN_W       (LEN_W)
    ) u_len (
        .coarse   (coarse),
        .lengthen (carry),
        .len      (next_len)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= LEN_W'(BASE_STAGES);
            long_q <= 1'b0;
        end else if (at_start) begin
            len_q  <= next_len;
            long_q <= carry;
        end
    end

    always_comb begin
        stage_count = at_start ? next_len : len_q;
        long_cycle  = at_start ? carry : long_q;
        cycle_start = at_start;
    end

    ring_dither_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_len  (stage_count),
        .at_start (at_start),
        .ring_clk (ring_clk)
    );
endmodule

// File: rtl/ring_dither_seq_chk.sv
module ring_dither_seq_chk #(
    parameter int COARSE_W    = 3,
    parameter int FINE_W      = 5,
    parameter int BASE_STAGES = 17,
    parameter int STAGE_STEP  = 2,
    localparam int WORD_W     = COARSE_W + FINE_W,
    localparam int MAX_LEN    = BASE_STAGES + STAGE_STEP * (2**COARSE_W - 1) + STAGE_STEP,
    localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] stage_word,
    input logic              ring_clk,
    input logic              cycle_start,
    input logic              long_cycle,
    input logic [LEN_W-1:0]  stage_count
);
    logic [7:0]       run_q;
    logic [LEN_W-1:0] prev_len_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            prev_len_q <= '0;
            seen_q     <= 1'b0;
        end else if (cycle_start) begin
            run_q      <= 8'd1;
            prev_len_q <= stage_count;
            seen_q     <= 1'b1;
        end else begin
            run_q <= run_q + 8'd1;
        end
    end

    AST_PERIOD_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && seen_q) |-> (run_q == 8'(prev_len_q))); // R1

    AST_LONG_ADDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (int'(stage_count) - (long_cycle ? STAGE_STEP : 0)
                         == BASE_STAGES + STAGE_STEP * int'(stage_word[WORD_W-1:FINE_W]))); // R2

    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> ring_clk); // R5

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |-> ($stable(stage_count) && $stable(long_cycle))); // R8

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_clk) |-> cycle_start); // R9
endmodule

bind ring_dither_seq ring_dither_seq_chk #(
    .COARSE_W    (COARSE_W),
    .FINE_W      (FINE_W),
    .BASE_STAGES (BASE_STAGES),
    .STAGE_STEP  (STAGE_STEP)
) u_chk (.*);

// File: tb/ring_dither_seq_bench.sv
module ring_dither_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stage_word = 8'h00;
    logic       ring_clk, cycle_start, long_cycle;
    logic [5:0] stage_count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_dither_seq u_ring_dither_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage_word  (stage_word),
        .ring_clk    (ring_clk),
        .cycle_start (cycle_start),
        .long_cycle  (long_cycle),
        .stage_count (stage_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Leaves the bench at a falling edge with the block at tick zero.
    task automatic do_reset(input logic [7:0] w);
        @(negedge clk);
        rst_n = 1'b0;
        stage_word = w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Starts at tick zero, returns at the next tick zero.
    task automatic measure(output int len, output int high, output int sc,
                           output bit lng, output bit steady, output bit shape);
        bit saw_low;
        sc = int'(stage_count);
        lng = long_cycle;
        len = 0; high = 0; steady = 1'b1; shape = 1'b1; saw_low = 1'b0;
        do begin
            if (ring_clk) begin
                high++;
                if (saw_low) shape = 1'b0;
            end else begin
                saw_low = 1'b1;
            end
            if (int'(stage_count) != sc || long_cycle != lng) steady = 1'b0;
            len++;
            @(negedge clk);
        end while (!cycle_start && len < 100);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stage_word = 8'hFF;
        repeat (2) @(negedge clk);
        check(cycle_start == 1'b1, "R7", "cycle_start in reset", int'(cycle_start), 1);
        check(ring_clk == 1'b1, "R7", "ring_clk in reset", int'(ring_clk), 1);
    endtask

    task automatic t_nominal(input int c);
        int len, high, sc; bit lng, steady, shape;
        do_reset({3'(c), 5'd0});
        for (int i = 0; i < 3; i++) begin
            measure(len, high, sc, lng, steady, shape);
            check(len == 17 + 2*c, "R1", "nominal length", len, 17 + 2*c);
            check(lng == 1'b0, "R1", "long flag with zero fraction", int'(lng), 0);
            check(sc == len, "R8", "stage_count vs length", sc, len);
            check(steady, "R8", "stage_count steady", int'(steady), 1);
            check(high == len/2, "R5", "high ticks", high, len/2);
            check(shape, "R5", "high before low", int'(shape), 1);
            check(len == sc, "R9", "cycle_start spacing", len, sc);
        end
    endtask

    task automatic t_frame(input int n);
        int len, high, sc, longs, exp_len; bit lng, steady, shape, exp_long;
        do_reset({3'd3, 5'(n)});
        longs = 0;
        for (int k = 1; k <= 64; k++) begin
            measure(len, high, sc, lng, steady, shape);
            exp_long = ((k*n)/32) > (((k-1)*n)/32);
            exp_len = 23 + (exp_long ? 2 : 0);
            check(len == exp_len, "R4", $sformatf("length N=%0d k=%0d", n, k), len, exp_len);
            check(lng == exp_long, "R2", $sformatf("long flag N=%0d k=%0d", n, k),
                  int'(lng), int'(exp_long));
            check(high == len/2, "R5", "high ticks in dithered cycle", high, len/2);
            if (k <= 32) longs += int'(lng);
            if (k == 32) check(longs == n, "R3", $sformatf("longs per frame N=%0d", n), longs, n);
        end
    endtask

    task automatic t_midchange();
        int len, high, sc; bit lng, steady, shape;
        bit held;
        do_reset({3'd3, 5'd0});
        len = 0; held = 1'b1;
        do begin
            if (len == 5) stage_word = {3'd7, 5'd0};
            if (stage_count != 6'd23) held = 1'b0;
            len++;
            @(negedge clk);
        end while (!cycle_start && len < 100);
        check(len == 23, "R6", "length after mid-cycle change", len, 23);
        check(held, "R6", "stage_count held after change", int'(held), 1);
        measure(len, high, sc, lng, steady, shape);
        check(len == 31, "R6", "length of following cycle", len, 31);
    endtask

    task automatic t_reset_acc();
        int len, high, sc; bit lng, steady, shape;
        do_reset({3'd3, 5'd16});
        measure(len, high, sc, lng, steady, shape);
        check(lng == 1'b0, "R7", "first cycle short before reset", int'(lng), 0);
        measure(len, high, sc, lng, steady, shape);
        check(lng == 1'b1, "R7", "second cycle long before reset", int'(lng), 1);
        measure(len, high, sc, lng, steady, shape);
        repeat (4) @(negedge clk);
        do_reset({3'd3, 5'd16});
        measure(len, high, sc, lng, steady, shape);
        check(lng == 1'b0 && len == 23, "R7", "first cycle after mid reset", len, 23);
        measure(len, high, sc, lng, steady, shape);
        check(lng == 1'b1 && len == 25, "R7", "second cycle after mid reset", len, 25);
    endtask

    initial begin
        t_reset();
        t_nominal(0);
        t_nominal(3);
        t_nominal(7);
        t_frame(1);
        t_frame(5);
        t_frame(16);
        t_frame(31);
        t_midchange();
        t_reset_acc();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule